// File: doc/BRIEF.md
# Reconfigurable-Node Network Interface

This block is the static shim between one processing element and its mesh router. It stays outside the reconfigurable region, so it keeps running and keeps its state while the processing element behind it is rewritten. Each direction has a small decoupling buffer. On the egress side, flits from the processing element are queued and sent to the router under a credit count that starts at the router's input buffer depth. When the queue fills, the element is throttled. On the ingress side, flits from the router are queued, and one credit goes back to the router for every flit taken out of the queue.

The ingress path also inspects each packet as it reaches the front of the queue. A packet whose head carries the reconfiguration class code is a command. The interface consumes it, and the element never sees it. The command raises a busy level towards the reconfiguration port, and while that level is high the element can neither send nor receive. Data that arrives during this time waits in the ingress buffer. Once the buffer is full, no credits go back to the router, so nothing is dropped. A done strobe from the reconfiguration port ends the isolation and raises a one-cycle request, which the surrounding node uses to send an acknowledge packet.

Top module: `pe_net_iface`

## Requirements
- R1: After reset, pe_tx_ready is 1. pe_rx_valid, rt_out_valid, rt_in_credit, rcfg_busy and ack_req are all 0.
- R2: A flit accepted from the element (pe_tx_valid and pe_tx_ready at a clock edge) is not yet on the router port after that edge. It appears on rt_out_flit with rt_out_valid high after the following edge, provided a credit is available. Flits leave in the order they were accepted.
- R3: The router credit count starts at RT_DEPTH. At most RT_DEPTH flits are sent without a credit return, and each rt_credit_ret pulse allows exactly one more flit to be sent.
- R4: pe_tx_ready is 0 whenever the egress buffer holds BUF_DEPTH flits.
- R5: Ingress data flits are presented on pe_rx_flit in arrival order. A flit taken by the element (pe_rx_valid and pe_rx_ready at an edge) produces a one-cycle rt_in_credit pulse after that edge.
- R6: A head (type 10) or single (type 11) flit whose class field, bits [FLIT_W-3 -: CLS_W], equals CFG_CLASS is a command. When it reaches the front of the ingress buffer it is consumed by the interface and never shown to the element. rcfg_busy rises after the edge that consumes it. Any later flits of the same packet, up to and including its tail (type 01), are consumed too, and each consumed command flit returns one rt_in_credit pulse.
- R7: While rcfg_busy is 1, pe_tx_ready and pe_rx_valid are both 0.
- R8: Data flits that arrive while rcfg_busy is 1 are kept. While they wait, no rt_in_credit is returned for them. After isolation ends they are delivered in arrival order.
- R9: rcfg_done while rcfg_busy is 1 clears rcfg_busy after the next edge and raises ack_req for exactly one cycle. rcfg_done while rcfg_busy is 0 changes nothing and raises no ack_req.
- R10: Flits already in the egress buffer when isolation starts still drain to the router as credits allow.
- R11: Flit type is carried in bits [FLIT_W-1:FLIT_W-2], encoded body 00, tail 01, head 10, single 11. The class field is examined only on head and single flits, so a body flit of a data packet is delivered as data whatever its class bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_tx_valid | input | 1 | Element offers an egress flit |
| pe_tx_flit | input | FLIT_W | Egress flit from element |
| pe_tx_ready | output | 1 | Egress flit accepted this cycle (throttle) |
| pe_rx_valid | output | 1 | Ingress data flit available to element |
| pe_rx_flit | output | FLIT_W | Ingress data flit |
| pe_rx_ready | input | 1 | Element takes the ingress flit |
| rt_out_valid | output | 1 | Flit sent to router this cycle |
| rt_out_flit | output | FLIT_W | Flit to router |
| rt_credit_ret | input | 1 | Router freed one input slot |
| rt_in_valid | input | 1 | Router delivers a flit |
| rt_in_flit | input | FLIT_W | Flit from router |
| rt_in_credit | output | 1 | One ingress slot freed, credit back to router |
| rcfg_busy | output | 1 | Local element under reconfiguration |
| rcfg_done | input | 1 | Reconfiguration finished strobe |
| ack_req | output | 1 | One-cycle request to send the acknowledge packet |

## Verification
The egress result is due two edges after the flit is offered: one edge to queue it and one to register it onto the router port. Ingress data shows on pe_rx_flit right after the edge that queues it, and rt_in_credit and rcfg_busy follow the edge that pops the flit from the front of the queue. rcfg_busy falls and ack_req rises right after the edge that samples rcfg_done. The directed tasks drive inputs at the falling edge, advance by whole cycles, and compare at the falling edge that follows the rising edge where each result is due. Credit exhaustion and release are timed the same way, counting the edge that loads the credit and the edge that sends.

// File: rtl/niface_pkg.sv
package niface_pkg;

   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      FK_BODY   = 2'b00,
      FK_TAIL   = 2'b01,
      FK_HEAD   = 2'b10,
      FK_SINGLE = 2'b11
   } flit_kind_e;

   function automatic logic kind_opens(input logic [KIND_W-1:0] k);
      return (k == FK_HEAD) || (k == FK_SINGLE);
   endfunction

   function automatic logic kind_closes(input logic [KIND_W-1:0] k);
      return (k == FK_TAIL) || (k == FK_SINGLE);
   endfunction

endpackage

// File: rtl/ni_fifo.sv
module ni_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else
         cnt <= cnt + CW'(push) - CW'(pop);
   end

   generate
      if (DEPTH == 1) begin : g_one
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (push) slot <= din;
         end
         assign dout = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] rd_ptr, wr_ptr;

         always_ff @(posedge clk) begin
            if (push) mem[wr_ptr] <= din;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_ptr <= '0;
               wr_ptr <= '0;
            end else begin
               if (push)
                  wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
               if (pop)
                  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
         end
         assign dout = mem[rd_ptr];
      end
   endgenerate

   initial begin
      depth_param_chk: assert (DEPTH >= 1) else $error("ni_fifo: DEPTH must be >= 1");
      width_param_chk: assert (W >= 1) else $error("ni_fifo: W must be >= 1");
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !(push && !pop));

   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/ni_tx_path.sv
module ni_tx_path #(
   parameter int W        = 16,
   parameter int RT_DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         q_empty,
   input  logic [W-1:0] q_head,
   output logic         q_pop,
   input  logic         credit_ret,
   output logic         out_valid,
   output logic [W-1:0] out_flit
);
   localparam int CRW = $clog2(RT_DEPTH + 1);

   logic [CRW-1:0] credits;

   assign q_pop = !q_empty && (credits != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         credits   <= CRW'(RT_DEPTH);
         out_valid <= 1'b0;
         out_flit  <= '0;
      end else begin
         credits   <= credits + CRW'(credit_ret) - CRW'(q_pop);
         out_valid <= q_pop;
         if (q_pop) out_flit <= q_head;
      end
   end

   initial begin
      rt_depth_param_chk: assert (RT_DEPTH >= 1) else $error("ni_tx_path: RT_DEPTH must be >= 1");
   end

   // R3
   credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      credits <= CRW'(RT_DEPTH));

   // R3
   send_with_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(credits) != '0));

endmodule

// File: rtl/ni_rx_ctrl.sv
module ni_rx_ctrl
   import niface_pkg::*;
#(
   parameter int CLS_W     = 2,
   parameter int CFG_CLASS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [KIND_W-1:0] head_kind,
   input  logic [CLS_W-1:0]  head_cls,
   output logic              q_pop,
   output logic              pe_valid,
   input  logic              pe_ready,
   input  logic              done_in,
   output logic              busy,
   output logic              ack_req,
   output logic              credit_out
);
   logic in_cmd;
   logic front_cmd;
   logic cmd_start;

   assign front_cmd = !q_empty &&
                      (in_cmd || (kind_opens(head_kind) && (head_cls == CLS_W'(CFG_CLASS))));
   assign cmd_start = front_cmd && !in_cmd;
   assign pe_valid  = !q_empty && !front_cmd && !busy;
   assign q_pop     = front_cmd || (pe_valid && pe_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cmd     <= 1'b0;
         busy       <= 1'b0;
         ack_req    <= 1'b0;
         credit_out <= 1'b0;
      end else begin
         credit_out <= q_pop;
         ack_req    <= busy && done_in;
         if (front_cmd)
            in_cmd <= !kind_closes(head_kind);
         if (cmd_start)
            busy <= 1'b1;
         else if (done_in)
            busy <= 1'b0;
      end
   end

   initial begin
      cls_param_chk: assert (CFG_CLASS < (1 << CLS_W)) else $error("ni_rx_ctrl: CFG_CLASS exceeds class field");
   end

   // R6
   cmd_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pe_valid |-> !in_cmd);

   // R7
   iso_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pe_valid);

   // R9
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> !ack_req);

   // R9
   ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |-> $past(busy));

endmodule

// File: rtl/pe_net_iface.sv
module pe_net_iface
   import niface_pkg::*;
#(
   parameter int FLIT_W    = 16,
   parameter int BUF_DEPTH = 2,
   parameter int RT_DEPTH  = 4,
   parameter int CLS_W     = 2,
   parameter int CFG_CLASS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pe_tx_valid,
   input  logic [FLIT_W-1:0] pe_tx_flit,
   output logic              pe_tx_ready,
   output logic              pe_rx_valid,
   output logic [FLIT_W-1:0] pe_rx_flit,
   input  logic              pe_rx_ready,
   output logic              rt_out_valid,
   output logic [FLIT_W-1:0] rt_out_flit,
   input  logic              rt_credit_ret,
   input  logic              rt_in_valid,
   input  logic [FLIT_W-1:0] rt_in_flit,
   output logic              rt_in_credit,
   output logic              rcfg_busy,
   input  logic              rcfg_done,
   output logic              ack_req
);
   localparam int KIND_HI = FLIT_W - 1;
   localparam int CLS_HI  = FLIT_W - 1 - KIND_W;

   logic              eg_empty, eg_full, eg_pop, eg_push;
   logic [FLIT_W-1:0] eg_head;
   logic              in_empty, in_full, in_pop;
   logic [FLIT_W-1:0] in_head;

   assign pe_tx_ready = !eg_full && !rcfg_busy;
   assign eg_push     = pe_tx_valid && pe_tx_ready;

   ni_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_eg_q (
      .clk(clk), .rst_n(rst_n),
      .push(eg_push), .din(pe_tx_flit),
      .pop(eg_pop), .dout(eg_head),
      .empty(eg_empty), .full(eg_full)
   );

   ni_tx_path #(.W(FLIT_W), .RT_DEPTH(RT_DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .q_empty(eg_empty), .q_head(eg_head), .q_pop(eg_pop),
      .credit_ret(rt_credit_ret),
      .out_valid(rt_out_valid), .out_flit(rt_out_flit)
   );

   ni_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_in_q (
      .clk(clk), .rst_n(rst_n),
      .push(rt_in_valid), .din(rt_in_flit),
      .pop(in_pop), .dout(in_head),
      .empty(in_empty), .full(in_full)
   );

   assign pe_rx_flit = in_head;

   ni_rx_ctrl #(.CLS_W(CLS_W), .CFG_CLASS(CFG_CLASS)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .q_empty(in_empty),
      .head_kind(in_head[KIND_HI -: KIND_W]),
      .head_cls(in_head[CLS_HI -: CLS_W]),
      .q_pop(in_pop),
      .pe_valid(pe_rx_valid), .pe_ready(pe_rx_ready),
      .done_in(rcfg_done),
      .busy(rcfg_busy), .ack_req(ack_req),
      .credit_out(rt_in_credit)
   );

   initial begin
      flit_w_param_chk: assert (FLIT_W >= KIND_W + CLS_W) else $error("pe_net_iface: FLIT_W too narrow for type and class fields");
      buf_param_chk: assert (BUF_DEPTH >= 1) else $error("pe_net_iface: BUF_DEPTH must be >= 1");
   end

   // R7
   iso_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rcfg_busy |-> !pe_tx_ready);

   // R4
   throttle_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eg_full |-> !pe_tx_ready);

   // R8
   held_no_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcfg_busy && !in_empty && !in_pop) |=> !rt_in_credit);

   // R6
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rcfg_busy) |-> rt_in_credit);

endmodule

// File: tb/sim_pe_net_iface.sv
module sim_pe_net_iface;
   localparam int FW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pe_tx_valid = 1'b0;
   logic [FW-1:0] pe_tx_flit = '0;
   logic          pe_tx_ready;
   logic          pe_rx_valid;
   logic [FW-1:0] pe_rx_flit;
   logic          pe_rx_ready = 1'b0;
   logic          rt_out_valid;
   logic [FW-1:0] rt_out_flit;
   logic          rt_credit_ret = 1'b0;
   logic          rt_in_valid = 1'b0;
   logic [FW-1:0] rt_in_flit = '0;
   logic          rt_in_credit;
   logic          rcfg_busy;
   logic          rcfg_done = 1'b0;
   logic          ack_req;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pe_net_iface u0 (
      .clk(clk), .rst_n(rst_n),
      .pe_tx_valid(pe_tx_valid), .pe_tx_flit(pe_tx_flit), .pe_tx_ready(pe_tx_ready),
      .pe_rx_valid(pe_rx_valid), .pe_rx_flit(pe_rx_flit), .pe_rx_ready(pe_rx_ready),
      .rt_out_valid(rt_out_valid), .rt_out_flit(rt_out_flit), .rt_credit_ret(rt_credit_ret),
      .rt_in_valid(rt_in_valid), .rt_in_flit(rt_in_flit), .rt_in_credit(rt_in_credit),
      .rcfg_busy(rcfg_busy), .rcfg_done(rcfg_done), .ack_req(ack_req)
   );

   // type in [15:14]: 00 body, 01 tail, 10 head, 11 single; class in [13:12]; command class 3
   function automatic logic [FW-1:0] mk(input logic [1:0] kind, input logic [1:0] cls, input logic [11:0] pl);
      return {kind, cls, pl};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rt_send(input logic [FW-1:0] f);
      rt_in_valid = 1'b1;
      rt_in_flit  = f;
      step();
      rt_in_valid = 1'b0;
   endtask

   task automatic pe_take(input logic [FW-1:0] f, input string tag);
      check({tag, " rx valid"}, 32'(pe_rx_valid), 32'd1);
      check({tag, " rx flit"}, 32'(pe_rx_flit), 32'(f));
      pe_rx_ready = 1'b1;
      step();
      pe_rx_ready = 1'b0;
      check({tag, " credit back"}, 32'(rt_in_credit), 32'd1);
   endtask

   task automatic ret_credits(input int n);
      for (int i = 0; i < n; i++) begin
         rt_credit_ret = 1'b1;
         step();
      end
      rt_credit_ret = 1'b0;
      step();
   endtask

   task automatic t_reset();
      check("R1 tx_ready", 32'(pe_tx_ready), 32'd1);
      check("R1 rx_valid", 32'(pe_rx_valid), 32'd0);
      check("R1 out_valid", 32'(rt_out_valid), 32'd0);
      check("R1 in_credit", 32'(rt_in_credit), 32'd0);
      check("R1 busy", 32'(rcfg_busy), 32'd0);
      check("R1 ack", 32'(ack_req), 32'd0);
   endtask

   task automatic t_egress();
      logic [FW-1:0] a, b;
      a = mk(2'b10, 2'b00, 12'h0A1);
      b = mk(2'b01, 2'b00, 12'h0A2);
      pe_tx_valid = 1'b1; pe_tx_flit = a;
      step();
      pe_tx_flit = b;
      check("R2 not yet out", 32'(rt_out_valid), 32'd0);
      step();
      pe_tx_valid = 1'b0;
      check("R2 first valid", 32'(rt_out_valid), 32'd1);
      check("R2 first flit", 32'(rt_out_flit), 32'(a));
      step();
      check("R2 second flit order", 32'(rt_out_flit), 32'(b));
      check("R2 second valid", 32'(rt_out_valid), 32'd1);
      step();
      check("R2 idle after", 32'(rt_out_valid), 32'd0);
      ret_credits(2);
   endtask

   task automatic t_credit();
      int acc = 0;
      int sent = 0;
      for (int c = 0; c < 12; c++) begin
         logic r;
         if (rt_out_valid) begin
            check("R3 send order", 32'(rt_out_flit), 32'(16'hC100 + sent));
            sent++;
         end
         pe_tx_valid = (acc < 6);
         pe_tx_flit  = 16'hC100 + FW'(acc);
         r = pe_tx_ready;
         step();
         if (pe_tx_valid && r) acc++;
      end
      pe_tx_valid = 1'b0;
      check("R3 sends limited by credit", 32'(sent), 32'd4);
      check("R3 no send without credit", 32'(rt_out_valid), 32'd0);
      check("R4 accepted up to buffer", 32'(acc), 32'd6);
      check("R4 throttle when full", 32'(pe_tx_ready), 32'd0);
      rt_credit_ret = 1'b1;
      step();
      rt_credit_ret = 1'b0;
      check("R3 credit loaded, not sent yet", 32'(rt_out_valid), 32'd0);
      step();
      check("R3 one credit one flit", 32'(rt_out_valid), 32'd1);
      check("R3 released flit", 32'(rt_out_flit), 32'(16'hC104));
      step();
      check("R3 only one per credit", 32'(rt_out_valid), 32'd0);
      rt_credit_ret = 1'b1;
      step();
      rt_credit_ret = 1'b0;
      step();
      check("R3 last flit out", 32'(rt_out_flit), 32'(16'hC105));
      ret_credits(4);
   endtask

   task automatic t_ingress();
      logic [FW-1:0] h, bd, tl;
      h  = mk(2'b10, 2'b00, 12'h111);
      bd = mk(2'b00, 2'b11, 12'h222);
      tl = mk(2'b01, 2'b00, 12'h333);
      rt_send(h);
      rt_send(bd);
      pe_take(h, "R5 head");
      pe_take(bd, "R11 body with command-like class");
      rt_send(tl);
      pe_take(tl, "R5 tail");
      check("R5 empty after", 32'(pe_rx_valid), 32'd0);
   endtask

   task automatic t_reconfig();
      logic [FW-1:0] x, d1, d2;
      x  = mk(2'b11, 2'b00, 12'hEEE);
      d1 = mk(2'b11, 2'b00, 12'hD01);
      d2 = mk(2'b11, 2'b01, 12'hD02);
      // use up all router credits
      pe_tx_valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
         pe_tx_flit = 16'hB000 + FW'(i);
         step();
      end
      pe_tx_valid = 1'b0;
      step();
      step();
      pe_tx_valid = 1'b1; pe_tx_flit = x;
      step();
      pe_tx_valid = 1'b0;
      step();
      check("R10 waits for credit", 32'(rt_out_valid), 32'd0);
      // command packet head + tail
      rt_send(mk(2'b10, 2'b11, 12'h0C0));
      check("R6 command not shown", 32'(pe_rx_valid), 32'd0);
      check("R6 busy not before pop", 32'(rcfg_busy), 32'd0);
      step();
      check("R6 busy raised", 32'(rcfg_busy), 32'd1);
      check("R6 command credit", 32'(rt_in_credit), 32'd1);
      check("R7 tx blocked", 32'(pe_tx_ready), 32'd0);
      rt_send(mk(2'b01, 2'b00, 12'h0C1));
      check("R6 tail not shown", 32'(pe_rx_valid), 32'd0);
      step();
      check("R6 tail credit", 32'(rt_in_credit), 32'd1);
      check("R6 busy held", 32'(rcfg_busy), 32'd1);
      rt_credit_ret = 1'b1;
      step();
      rt_credit_ret = 1'b0;
      step();
      check("R10 drains while busy", 32'(rt_out_valid), 32'd1);
      check("R10 drained flit", 32'(rt_out_flit), 32'(x));
      rt_send(d1);
      rt_send(d2);
      for (int i = 0; i < 3; i++) begin
         check("R7 rx blocked", 32'(pe_rx_valid), 32'd0);
         check("R8 no credit while held", 32'(rt_in_credit), 32'd0);
         step();
      end
      rcfg_done = 1'b1;
      step();
      rcfg_done = 1'b0;
      check("R9 busy cleared", 32'(rcfg_busy), 32'd0);
      check("R9 ack raised", 32'(ack_req), 32'd1);
      pe_take(d1, "R8 first held");
      check("R9 ack one cycle", 32'(ack_req), 32'd0);
      pe_take(d2, "R8 second held");
      // done while idle
      rcfg_done = 1'b1;
      step();
      rcfg_done = 1'b0;
      check("R9 idle done no ack", 32'(ack_req), 32'd0);
      check("R9 idle done no busy", 32'(rcfg_busy), 32'd0);
      // single-flit command
      rt_send(mk(2'b11, 2'b11, 12'h0C2));
      step();
      check("R6 single command busy", 32'(rcfg_busy), 32'd1);
      rcfg_done = 1'b1;
      step();
      rcfg_done = 1'b0;
      check("R9 second ack", 32'(ack_req), 32'd1);
      check("R1 tx ready again", 32'(pe_tx_ready), 32'd1);
      ret_credits(4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_egress();
      t_credit();
      t_ingress();
      t_reconfig();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule